// File: doc/BRIEF.md
# Context-Switch Microcode Sequencer

This block runs a short stored program that steers the saving and restoring of graphics state during a context switch. Programs are 24-bit words held in a 256-entry instruction RAM, loaded through a simple write port while the sequencer is idle. A start pulse launches the program at address 0. The program tests and writes a bank of single-bit flags and stalls on status flags that come from outside. It branches on flag values. It also issues transfer requests, each asking an external engine to move a run of consecutive registers between the hardware and a context buffer, in the direction held by flag 0.

The opcode class sits in bits 23:20 of each word. Commands the sequencer does not interpret itself are presented on an opcode strobe for logic outside the block. The current length/scratch value goes with them, so that a bulk command can use it. The end word raises a done indication. An unknown class stops the program with an error indication. Flags are numbered word*32+bit. Flags 0 to 95 are internal and writable. Flags 96 to 127 mirror a 32-bit status input, and flag 104 always reads as 1.

Top module: `ctxsw_sequencer`

## Requirements
- R1: After reset, and until a start pulse, busy, done, error, xfer_req and op_valid are all 0. At most one of busy, done and error is ever 1.
- R2: A word of class 1 (bit 20, bits 23:21 zero) raises xfer_req with xfer_addr = bits 13:0, xfer_count = bits 19:14 (0 and 63 both legal), and xfer_save = the value of flag 0 when the word executes (1 = save, 0 = load).
- R3: xfer_req stays 1 with stable address, count and direction until xfer_ack is sampled high. It is 0 in the cycle after the acknowledge, including an acknowledge given in the first cycle of the request.
- R4: A word of class 2 loads bits 19:0 into the length register. The register keeps its value across later starts, and op_len reports it with every strobed word.
- R5: A word of class 4 branches to bits 15:8. With bit 7 = 0 it is taken when the flag selected by bits 6:0 is 1; with bit 7 = 1 it is taken when that flag is 0. Otherwise execution continues at the next word, and a skipped word has no effect.
- R6: A word of class 5 holds the program counter until the flag selected by bits 6:0 equals bit 7; busy stays 1 meanwhile.
- R7: A word of class 7 writes bit 7 into the flag selected by bits 6:0 when that index is below 96.
- R8: Flag index 96+k reads status input bit k. Flag 104 always reads 1. Writes to indices 96 to 127 are ignored.
- R9: The word 0x60000e stops the program and sets done. In the same step it clears flags 5 and 6.
- R10: Every other word of class 6, and every word of class 8, is shown for one cycle on op_valid/op_word, with op_len = length register.
- R11: A word of class 0, 3 or 9 to 15 stops the program with error = 1 and no further requests or strobes.
- R12: A start pulse while idle, done or in error restarts execution at address 0 and clears done and error. Start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| im_we | input | 1 | Instruction RAM write enable |
| im_addr | input | 8 | Instruction RAM write address |
| im_wdata | input | 24 | Instruction word to write |
| start | input | 1 | Launch the program at address 0 |
| ext_status | input | 32 | Status inputs seen as flags 96 to 127 |
| xfer_ack | input | 1 | Transfer engine accepts the request |
| xfer_req | output | 1 | Transfer request pending |
| xfer_addr | output | 14 | First register index of the run |
| xfer_count | output | 6 | Number of registers in the run |
| xfer_save | output | 1 | 1 = save to buffer, 0 = load from buffer |
| op_valid | output | 1 | Strobe for a word handled outside |
| op_word | output | 24 | The strobed word |
| op_len | output | 20 | Length register value with the strobe |
| busy | output | 1 | Program running |
| done | output | 1 | Program reached its end word |
| error | output | 1 | Program stopped on an unknown class |

## Verification
Two functions can meet in one cycle: a transfer acknowledge and the first cycle of its own request. The bench acknowledges one transfer in that first cycle and delays another by several cycles. It checks that each request is reported once, with the right fields, and that it stays up for exactly the acknowledge delay plus one. A second case is a status input changing while a wait is pending. The bench holds the flag a waiting word is blocked on for many cycles, then drops it. It requires that no strobe or done appears before the release, and that the program resumes after it.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

    localparam int unsigned INSN_W   = 24;
    localparam int unsigned PC_W     = 8;
    localparam int unsigned RADDR_W  = 14;
    localparam int unsigned RCNT_W   = 6;
    localparam int unsigned LEN_W    = 20;
    localparam int unsigned FIDX_W   = 7;
    localparam int unsigned NFLAG    = 1 << FIDX_W;
    localparam int unsigned NINT     = 96;
    localparam int unsigned EXT_W    = NFLAG - NINT;
    localparam int unsigned TRUE_IDX = 104;
    localparam int unsigned DIR_IDX  = 0;
    localparam int unsigned USV_IDX  = 5;
    localparam int unsigned ULD_IDX  = 6;

    localparam logic [INSN_W-1:0] STOP_WORD = 24'h60000e;

    typedef enum logic [2:0] {
        K_XFER, K_LOAD, K_BRA, K_WAIT, K_STOP, K_EMIT, K_SET, K_BAD
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [PC_W-1:0]     target;
        logic                pol;
        logic [FIDX_W-1:0]   fidx;
        logic [RADDR_W-1:0]  raddr;
        logic [RCNT_W-1:0]   rcnt;
        logic [LEN_W-1:0]    imm;
        logic [INSN_W-1:0]   raw;
    } insn_t;

    typedef enum logic [2:0] {
        S_IDLE, S_RUN, S_XFER, S_DONE, S_ERR
    } seq_state_e;

endpackage

// File: rtl/ctxsw_imem.sv
module ctxsw_imem #(
    parameter int unsigned DW = 24,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ctxsw_decode.sv
module ctxsw_decode
    import ctxsw_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output insn_t             insn
);
    always_comb begin
        insn.raw    = word;
        insn.target = word[15:8];
        insn.pol    = word[7];
        insn.fidx   = word[6:0];
        insn.raddr  = word[13:0];
        insn.rcnt   = word[19:14];
        insn.imm    = word[19:0];
        unique case (word[23:20])
            4'h1:    insn.kind = K_XFER;
            4'h2:    insn.kind = K_LOAD;
            4'h4:    insn.kind = K_BRA;
            4'h5:    insn.kind = K_WAIT;
            4'h6:    insn.kind = (word == STOP_WORD) ? K_STOP : K_EMIT;
            4'h7:    insn.kind = K_SET;
            4'h8:    insn.kind = K_EMIT;
            default: insn.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/ctxsw_flagbank.sv
module ctxsw_flagbank
    import ctxsw_pkg::*;
#(
    parameter int unsigned N_INT   = NINT,
    parameter int unsigned N_EXT   = EXT_W,
    parameter int unsigned TRUE_AT = TRUE_IDX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FIDX_W-1:0] wr_idx,
    input  logic              wr_val,
    input  logic              clr_user,
    input  logic [N_EXT-1:0]  ext_status,
    input  logic [FIDX_W-1:0] rd_idx,
    output logic              rd_val,
    output logic              dir
);
    localparam int unsigned N_ALL = N_INT + N_EXT;

    logic [N_INT-1:0] int_d, int_q;
    logic [N_ALL-1:0] view;
    logic             wr_ok;

    assign wr_ok = wr_en && (wr_idx < FIDX_W'(N_INT));

    always_comb begin
        int_d = int_q;
        if (wr_ok) int_d[wr_idx] = wr_val;
        if (clr_user) begin
            int_d[USV_IDX] = 1'b0;
            int_d[ULD_IDX] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_q <= '0;
        else        int_q <= int_d;
    end

    always_comb begin
        view = {ext_status, int_q};
        view[TRUE_AT] = 1'b1;
    end

    assign rd_val = view[rd_idx];
    assign dir    = int_q[DIR_IDX];

    assert_user_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_user |=> (!int_q[USV_IDX] && !int_q[ULD_IDX]));

    assert_ro_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_user && (wr_idx >= FIDX_W'(N_INT))) |=> $stable(int_q));

    assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_user && (wr_idx == FIDX_W'(DIR_IDX))) |=> (dir == $past(wr_val)));

endmodule

// File: rtl/ctxsw_sequencer.sv
module ctxsw_sequencer
    import ctxsw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               im_we,
    input  logic [PC_W-1:0]    im_addr,
    input  logic [INSN_W-1:0]  im_wdata,
    input  logic               start,
    input  logic [EXT_W-1:0]   ext_status,
    input  logic               xfer_ack,
    output logic               xfer_req,
    output logic [RADDR_W-1:0] xfer_addr,
    output logic [RCNT_W-1:0]  xfer_count,
    output logic               xfer_save,
    output logic               op_valid,
    output logic [INSN_W-1:0]  op_word,
    output logic [LEN_W-1:0]   op_len,
    output logic               busy,
    output logic               done,
    output logic               error
);
    typedef struct packed {
        seq_state_e          state;
        logic [PC_W-1:0]     pc;
        logic [LEN_W-1:0]    len;
        logic                req;
        logic [RADDR_W-1:0]  raddr;
        logic [RCNT_W-1:0]   rcnt;
        logic                save;
        logic                ovld;
        logic [INSN_W-1:0]   oword;
        logic [LEN_W-1:0]    olen;
    } seq_t;

    seq_t s_d, s_q;

    logic [INSN_W-1:0] fetch_word;
    insn_t             ins;
    logic              flag_rd;
    logic              cur_dir;
    logic              fl_we;
    logic              fl_clr;

    ctxsw_imem #(.DW(INSN_W), .AW(PC_W)) u_imem (
        .clk   (clk),
        .we    (im_we),
        .waddr (im_addr),
        .wdata (im_wdata),
        .raddr (s_q.pc),
        .rdata (fetch_word)
    );

    ctxsw_decode u_dec (
        .word (fetch_word),
        .insn (ins)
    );

    ctxsw_flagbank u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (fl_we),
        .wr_idx     (ins.fidx),
        .wr_val     (ins.pol),
        .clr_user   (fl_clr),
        .ext_status (ext_status),
        .rd_idx     (ins.fidx),
        .rd_val     (flag_rd),
        .dir        (cur_dir)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ovld = 1'b0;
        fl_we    = 1'b0;
        fl_clr   = 1'b0;
        unique case (s_q.state)
            S_IDLE, S_DONE, S_ERR: begin
                if (start) begin
                    s_d.state = S_RUN;
                    s_d.pc    = '0;
                end
            end
            S_RUN: begin
                unique case (ins.kind)
                    K_XFER: begin
                        s_d.state = S_XFER;
                        s_d.req   = 1'b1;
                        s_d.raddr = ins.raddr;
                        s_d.rcnt  = ins.rcnt;
                        s_d.save  = cur_dir;
                    end
                    K_LOAD: begin
                        s_d.len = ins.imm;
                        s_d.pc  = PC_W'(s_q.pc + 1'b1);
                    end
                    K_BRA: begin
                        s_d.pc = (flag_rd ^ ins.pol) ? ins.target : PC_W'(s_q.pc + 1'b1);
                    end
                    K_WAIT: begin
                        if (flag_rd == ins.pol) s_d.pc = PC_W'(s_q.pc + 1'b1);
                    end
                    K_STOP: begin
                        s_d.state = S_DONE;
                        fl_clr    = 1'b1;
                    end
                    K_EMIT: begin
                        s_d.ovld  = 1'b1;
                        s_d.oword = ins.raw;
                        s_d.olen  = s_q.len;
                        s_d.pc    = PC_W'(s_q.pc + 1'b1);
                    end
                    K_SET: begin
                        fl_we   = 1'b1;
                        s_d.pc  = PC_W'(s_q.pc + 1'b1);
                    end
                    default: begin
                        s_d.state = S_ERR;
                    end
                endcase
            end
            S_XFER: begin
                if (xfer_ack) begin
                    s_d.req   = 1'b0;
                    s_d.state = S_RUN;
                    s_d.pc    = PC_W'(s_q.pc + 1'b1);
                end
            end
            default: s_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign xfer_req   = s_q.req;
    assign xfer_addr  = s_q.raddr;
    assign xfer_count = s_q.rcnt;
    assign xfer_save  = s_q.save;
    assign op_valid   = s_q.ovld;
    assign op_word    = s_q.oword;
    assign op_len     = s_q.olen;
    assign busy       = (s_q.state == S_RUN) || (s_q.state == S_XFER);
    assign done       = (s_q.state == S_DONE);
    assign error      = (s_q.state == S_ERR);

    assert_status_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, error}));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_addr)
                                     && $stable(xfer_count) && $stable(xfer_save)));

    assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack) |=> !xfer_req);

    assert_wait_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_req && ins.kind == K_WAIT && flag_rd != ins.pol) |=> (busy && $stable(s_q.pc)));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> (error && !xfer_req && !op_valid));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && !xfer_req));

endmodule

// File: tb/test_ctxsw_sequencer.sv
module test_ctxsw_sequencer;

    typedef struct packed {
        logic [1:0]  kind;
        logic [23:0] word;
        logic [19:0] len;
        logic [5:0]  cnt;
        logic        save;
    } item_t;

    localparam logic [1:0] I_XFER = 2'd0;
    localparam logic [1:0] I_OP   = 2'd1;
    localparam logic [1:0] I_DONE = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        im_we = 1'b0;
    logic [7:0]  im_addr = '0;
    logic [23:0] im_wdata = '0;
    logic        start = 1'b0;
    logic [31:0] ext_status = '0;
    logic        xfer_ack = 1'b0;
    logic        xfer_req;
    logic [13:0] xfer_addr;
    logic [5:0]  xfer_count;
    logic        xfer_save;
    logic        op_valid;
    logic [23:0] op_word;
    logic [19:0] op_len;
    logic        busy;
    logic        done;
    logic        error;

    int n_checks = 0;
    int n_errs   = 0;
    int ack_delay = 0;
    int wcnt = 0;
    int req_len = 0;
    logic req_prev = 1'b0;
    logic done_prev = 1'b0;

    item_t exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    ctxsw_sequencer i_ctxsw_sequencer (
        .clk(clk), .rst_n(rst_n), .im_we(im_we), .im_addr(im_addr), .im_wdata(im_wdata),
        .start(start), .ext_status(ext_status), .xfer_ack(xfer_ack),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_count(xfer_count),
        .xfer_save(xfer_save), .op_valid(op_valid), .op_word(op_word), .op_len(op_len),
        .busy(busy), .done(done), .error(error)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    task automatic push(input logic [1:0] k, input logic [23:0] w, input logic [19:0] l,
                        input logic [5:0] c, input logic s, input string tag);
        item_t it;
        it.kind = k; it.word = w; it.len = l; it.cnt = c; it.save = s;
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    task automatic compare_item(input item_t act);
        item_t e;
        string t;
        if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected event", 64'(act), 64'h0);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(act == e, t, 64'(act), 64'(e));
        end
    endtask

    always @(negedge clk) begin
        item_t a;
        if (rst_n) begin
            if (xfer_req) begin
                if (!req_prev) begin
                    a.kind = I_XFER; a.word = {10'd0, xfer_addr}; a.len = '0;
                    a.cnt = xfer_count; a.save = xfer_save;
                    compare_item(a);
                    req_len = 0;
                end
                req_len++;
                xfer_ack = (wcnt == ack_delay);
                wcnt++;
            end else begin
                if (req_prev)
                    check(req_len == ack_delay + 1, "R3 request length", 64'(req_len), 64'(ack_delay + 1));
                xfer_ack = 1'b0;
                wcnt = 0;
            end
            if (op_valid) begin
                a.kind = I_OP; a.word = op_word; a.len = op_len; a.cnt = '0; a.save = 1'b0;
                compare_item(a);
            end
            if (done && !done_prev) begin
                a = '0; a.kind = I_DONE;
                compare_item(a);
            end
            req_prev  = xfer_req;
            done_prev = done;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [23:0] d);
        @(negedge clk);
        im_we = 1'b1; im_addr = a; im_wdata = d;
        @(negedge clk);
        im_we = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 2000; i++) begin
            if (done || error) break;
            @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !error, "R1 reset status", 64'({busy, done, error}), 64'd0);
        check(!xfer_req && !op_valid, "R1 reset outputs", 64'({xfer_req, op_valid}), 64'd0);

        // Program A: transfers, branches, strobes, protected flag
        wr(8'd0,  24'h700080);   // flag0 := 1 (save)
        wr(8'd1,  24'h10C123);   // xfer addr 0x123 count 3
        wr(8'd2,  24'h700000);   // flag0 := 0 (load)
        wr(8'd3,  24'h1FFFFF);   // xfer addr 0x3fff count 63
        wr(8'd4,  24'h400668);   // branch to 6 if flag104 set
        wr(8'd5,  24'h60000A);   // skipped
        wr(8'd6,  24'h600007);   // strobe
        wr(8'd7,  24'h2ABCDE);   // len := 0xABCDE
        wr(8'd8,  24'h800029);   // bulk strobe with len
        wr(8'd9,  24'h4005E8);   // branch to 5 if flag104 clear: not taken
        wr(8'd10, 24'h700085);   // flag5 := 1
        wr(8'd11, 24'h700068);   // write flag104 := 0 (ignored)
        wr(8'd12, 24'h4005E8);   // still not taken
        wr(8'd13, 24'h60000E);   // end
        repeat (10) @(negedge clk);
        check(!busy && !done, "R12 idle without start", 64'({busy, done}), 64'd0);

        ack_delay = 3;
        push(I_XFER, 24'h000123, 20'h0, 6'd3, 1'b1, "R2 xfer save R7");
        push(I_XFER, 24'h003FFF, 20'h0, 6'd63, 1'b0, "R2 xfer max fields");
        push(I_OP, 24'h600007, 20'h0, 6'd0, 1'b0, "R10 strobe after R5 branch");
        push(I_OP, 24'h800029, 20'hABCDE, 6'd0, 1'b0, "R4 bulk len");
        push(I_DONE, 24'h0, 20'h0, 6'd0, 1'b0, "R9 done R8");
        kick();
        wait_end();
        check(done && !error, "R9 program A end", 64'({done, error}), 64'h2);
        check(exp_q.size() == 0, "R5 program A items", 64'(exp_q.size()), 64'd0);

        // Program B: flag5 cleared by end, waits on status inputs
        wr(8'd0, 24'h400305);    // branch to 3 if flag5 set
        wr(8'd1, 24'h600009);
        wr(8'd2, 24'h400468);    // always to 4
        wr(8'd3, 24'h60000A);
        wr(8'd4, 24'h500060);    // wait flag96 == 0
        wr(8'd5, 24'h5000E4);    // wait flag100 == 1
        wr(8'd6, 24'h60000E);
        ext_status = 32'h0000_0001;
        push(I_OP, 24'h600009, 20'hABCDE, 6'd0, 1'b0, "R9 flag5 cleared R4 kept");
        push(I_DONE, 24'h0, 20'h0, 6'd0, 1'b0, "R6 done after waits");
        kick();
        repeat (20) @(negedge clk);
        check(busy && !done, "R6 stall on flag96", 64'({busy, done}), 64'h2);
        ext_status = 32'h0;
        repeat (10) @(negedge clk);
        check(busy && !done, "R6 stall on flag100", 64'({busy, done}), 64'h2);
        ext_status = 32'h0000_0010;
        wait_end();
        check(done, "R6 released", 64'(done), 64'd1);
        check(exp_q.size() == 0, "R6 program B items", 64'(exp_q.size()), 64'd0);
        ext_status = 32'h0;

        // Program C: acknowledge in first request cycle, zero count
        ack_delay = 0;
        wr(8'd0, 24'h700080);
        wr(8'd1, 24'h100000);
        wr(8'd2, 24'h60000E);
        push(I_XFER, 24'h000000, 20'h0, 6'd0, 1'b1, "R3 immediate ack R2");
        push(I_DONE, 24'h0, 20'h0, 6'd0, 1'b0, "R9 done C");
        kick();
        wait_end();
        check(exp_q.size() == 0, "R3 program C items", 64'(exp_q.size()), 64'd0);

        // Program D: unknown classes
        wr(8'd0, 24'h300000);
        kick();
        repeat (5) @(negedge clk);
        check(error && !done && !busy, "R11 class 3 error", 64'({error, done, busy}), 64'h4);
        wr(8'd0, 24'h912345);
        kick();
        repeat (5) @(negedge clk);
        check(error && !busy, "R11 class 9 error", 64'({error, busy}), 64'h2);
        check(exp_q.size() == 0, "R11 no events", 64'(exp_q.size()), 64'd0);
        wr(8'd0, 24'h60000E);
        push(I_DONE, 24'h0, 20'h0, 6'd0, 1'b0, "R12 restart from error");
        kick();
        wait_end();
        check(done && !error, "R12 error cleared", 64'({done, error}), 64'h2);
        check(exp_q.size() == 0, "R12 items", 64'(exp_q.size()), 64'd0);

        finish_run();
    end

endmodule